// File: doc/BRIEF.md
# Banked Sixteen-Pin GPIO Controller

This block is a sixteen-pin general-purpose I/O unit that sits behind a banked configuration port. The pins are split into two groups of eight. Each group has a direction, a data and an inversion register in the main I/O logical device, and an output-mode register (open-drain or push-pull) in a separate mode logical device. A shared enable register turns each group on or off. The logical device number arrives on its own input from the neighbouring configuration logic; this block only decodes register offsets within the two device numbers it owns.

The block drives a per-pin output enable and output value for the pads and samples pin levels through a two-flop synchronizer. Register writes take effect at the clock edge on which `cfg_wr` is sampled high. Read data is combinational from the currently addressed register.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset both direction registers read 0xFF, and the data, inversion, output-mode and enable registers read 0x00. Every `pin_oe` and `pin_out` bit is 0.
- R2: Pin p belongs to group p/8 at bit p mod 8. With `cfg_ldn` = 0x07, the group 0 direction, data and inversion registers sit at 0xE0, 0xE1 and 0xE2, and the group 1 registers at 0xE4, 0xE5 and 0xE6. The enable register sits at 0x30, with bit 0 for group 0 and bit 1 for group 1. With `cfg_ldn` = 0x0F, the output-mode registers sit at 0xE0 (group 0) and 0xE1 (group 1). Direction, inversion, mode and enable registers read back the value written; unused enable bits read 0.
- R3: A direction bit of 1 makes the pin an input, and an input pin never asserts `pin_oe`.
- R4: An output pin in push-pull mode (mode bit 0) of an enabled group drives `pin_oe` = 1 and `pin_out` = data bit XOR inversion bit. `pin_out` is 0 whenever `pin_oe` is 0.
- R5: An output pin in open-drain mode (mode bit 1) of an enabled group drives low (`pin_oe` = 1, `pin_out` = 0) when its data bit XOR inversion bit is 0, and releases (`pin_oe` = 0) when it is 1.
- R6: Reading a data register of an enabled group returns, per bit, the synchronized pin level for input pins and the latched output value for output pins, in both cases XORed with the inversion bit.
- R7: A group whose enable bit is 0 drives no `pin_oe` and no `pin_out`, and its data register reads 0x00.
- R8: A pin level change becomes visible in the data register read two clock edges after it is applied, not after one.
- R9: A write to any offset not listed in R2, or under any other `cfg_ldn`, changes no register, and a read of such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ldn | input | 8 | Selected logical device number |
| cfg_addr | input | 8 | Register offset within the logical device |
| cfg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed register (combinational) |
| pin_in | input | 16 | Pin levels from the pads (asynchronous) |
| pin_oe | output | 16 | Per-pin output enable to the pads |
| pin_out | output | 16 | Per-pin output value to the pads |

## Verification
The hardest case to reach is a data-register read that mixes the two value sources. That means one group with some inputs and some outputs, inversion set, and the group enabled, with the inputs settled through the synchronizer. The random phase reaches it by writing random values to all nine mapped registers, plus stray offsets and device numbers, in any order. Pin levels change only through a task that waits out the synchronizer, so every read and pad output is compared against a model of whatever register mix has built up. A directed step changes pins and reads the data register after one edge and then after two, to pin down the synchronizer depth.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int GRP_W = 8;

  typedef logic [GRP_W-1:0] grp_t;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_EN,
    RSEL_DIR,
    RSEL_DAT,
    RSEL_INV,
    RSEL_MODE
  } rsel_e;

  // Output enable per pin: only output pins (dir=0) of an enabled group;
  // open-drain pins enable the driver only while the effective level is 0.
  function automatic grp_t drive_oe(grp_t dir, grp_t eff, grp_t od, logic en);
    grp_t r;
    r = ~dir & (~od | ~eff);
    return en ? r : '0;
  endfunction

  // Output value per pin: only push-pull output pins present a level.
  function automatic grp_t drive_val(grp_t dir, grp_t eff, grp_t od, logic en);
    grp_t r;
    r = ~dir & ~od & eff;
    return en ? r : '0;
  endfunction

  // Data read: sampled level for inputs, latch for outputs, then inversion.
  function automatic grp_t read_val(grp_t dir, grp_t lat, grp_t smp, grp_t inv,
                                    logic en);
    grp_t r;
    r = ((dir & smp) | (~dir & lat)) ^ inv;
    return en ? r : '0;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [1:0]   settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  // Counts edges since reset so the latency check never looks before it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                settle_q <= '0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  assign dout = stage2_q;

  assert_two_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_cfg_decode.sv
module gpio_cfg_decode
  import gpio_bank_pkg::*;
#(
  parameter int          GROUPS      = 2,
  parameter int          GIDX_W      = 1,
  parameter logic [7:0]  LDN_IO      = 8'h07,
  parameter logic [7:0]  LDN_MODE    = 8'h0F,
  parameter logic [7:0]  ADDR_EN     = 8'h30,
  parameter logic [7:0]  BANK_BASE   = 8'hE0,
  parameter int          BANK_STRIDE = 4,
  parameter logic [7:0]  MODE_BASE   = 8'hE0
) (
  input  logic [7:0]        ldn,
  input  logic [7:0]        addr,
  input  logic              wr,
  output rsel_e             rsel,
  output logic [GIDX_W-1:0] rgrp,
  output logic              hit,
  output logic              wr_en,
  output logic [GROUPS-1:0] wr_dir,
  output logic [GROUPS-1:0] wr_dat,
  output logic [GROUPS-1:0] wr_inv,
  output logic [GROUPS-1:0] wr_mode
);

  always_comb begin
    rsel = RSEL_NONE;
    rgrp = '0;
    if (ldn == LDN_IO) begin
      if (addr == ADDR_EN) rsel = RSEL_EN;
      for (int g = 0; g < GROUPS; g++) begin
        if (addr == 8'(BANK_BASE + g * BANK_STRIDE)) begin
          rsel = RSEL_DIR;
          rgrp = GIDX_W'(g);
        end
        if (addr == 8'(BANK_BASE + g * BANK_STRIDE + 1)) begin
          rsel = RSEL_DAT;
          rgrp = GIDX_W'(g);
        end
        if (addr == 8'(BANK_BASE + g * BANK_STRIDE + 2)) begin
          rsel = RSEL_INV;
          rgrp = GIDX_W'(g);
        end
      end
    end else if (ldn == LDN_MODE) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (addr == 8'(MODE_BASE + g)) begin
          rsel = RSEL_MODE;
          rgrp = GIDX_W'(g);
        end
      end
    end
  end

  assign hit   = (rsel != RSEL_NONE);
  assign wr_en = wr && (rsel == RSEL_EN);

  for (genvar g = 0; g < GROUPS; g++) begin : g_strobe
    logic sel_g;
    assign sel_g      = wr && (rgrp == GIDX_W'(g));
    assign wr_dir[g]  = sel_g && (rsel == RSEL_DIR);
    assign wr_dat[g]  = sel_g && (rsel == RSEL_DAT);
    assign wr_inv[g]  = sel_g && (rsel == RSEL_INV);
    assign wr_mode[g] = sel_g && (rsel == RSEL_MODE);
  end

  // At most one register is written per access (R2 map has no overlap).
  always_comb begin
    assert_single_strobe_R2: assert ($onehot0({wr_en, wr_dir, wr_dat, wr_inv, wr_mode}));
  end

endmodule

// File: rtl/gpio_bank_group.sv
module gpio_bank_group
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_dir,
  input  logic wr_dat,
  input  logic wr_inv,
  input  logic wr_mode,
  input  grp_t wdata,
  input  logic grp_en,
  input  grp_t smp,
  output grp_t dir_o,
  output grp_t lat_o,
  output grp_t inv_o,
  output grp_t mode_o,
  output grp_t oe_o,
  output grp_t val_o,
  output grp_t rd_val_o
);

  grp_t dir_q, lat_q, inv_q, mode_q;
  grp_t eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      lat_q  <= '0;
      inv_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_dat)  lat_q  <= wdata;
      if (wr_inv)  inv_q  <= wdata;
      if (wr_mode) mode_q <= wdata;
    end
  end

  assign eff      = lat_q ^ inv_q;
  assign oe_o     = drive_oe(dir_q, eff, mode_q, grp_en);
  assign val_o    = drive_val(dir_q, eff, mode_q, grp_en);
  assign rd_val_o = read_val(dir_q, lat_q, smp, inv_q, grp_en);

  assign dir_o  = dir_q;
  assign lat_o  = lat_q;
  assign inv_o  = inv_q;
  assign mode_o = mode_q;

  assert_reset_values_R1: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '1 && lat_q == '0 && inv_q == '0 && mode_q == '0));

  assert_input_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & oe_o) == '0);

  assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & val_o) == '0);

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_en |-> (oe_o == '0 && val_o == '0 && rd_val_o == '0));

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int          GROUPS      = 2,
  parameter logic [7:0]  LDN_IO      = 8'h07,
  parameter logic [7:0]  LDN_MODE    = 8'h0F,
  parameter logic [7:0]  ADDR_EN     = 8'h30,
  parameter logic [7:0]  BANK_BASE   = 8'hE0,
  parameter int          BANK_STRIDE = 4,
  parameter logic [7:0]  MODE_BASE   = 8'hE0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                cfg_ldn,
  input  logic [7:0]                cfg_addr,
  input  logic                      cfg_wr,
  input  logic [7:0]                cfg_wdata,
  output logic [7:0]                cfg_rdata,
  input  logic [GROUPS*GRP_W-1:0]   pin_in,
  output logic [GROUPS*GRP_W-1:0]   pin_oe,
  output logic [GROUPS*GRP_W-1:0]   pin_out
);

  localparam int PINS   = GROUPS * GRP_W;
  localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  rsel_e             rsel;
  logic [GIDX_W-1:0] rgrp;
  logic              hit;
  logic              wr_en;
  logic [GROUPS-1:0] wr_dir, wr_dat, wr_inv, wr_mode;
  logic [GROUPS-1:0] en_q;
  logic [PINS-1:0]   pin_smp;

  grp_t dir_a  [GROUPS];
  grp_t lat_a  [GROUPS];
  grp_t inv_a  [GROUPS];
  grp_t mode_a [GROUPS];
  grp_t rd_a   [GROUPS];

  logic [PINS-1:0] dir_flat, lat_flat, inv_flat, mode_flat;

  gpio_in_sync #(.W(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_smp)
  );

  gpio_cfg_decode #(
    .GROUPS     (GROUPS),
    .GIDX_W     (GIDX_W),
    .LDN_IO     (LDN_IO),
    .LDN_MODE   (LDN_MODE),
    .ADDR_EN    (ADDR_EN),
    .BANK_BASE  (BANK_BASE),
    .BANK_STRIDE(BANK_STRIDE),
    .MODE_BASE  (MODE_BASE)
  ) u_dec (
    .ldn    (cfg_ldn),
    .addr   (cfg_addr),
    .wr     (cfg_wr),
    .rsel   (rsel),
    .rgrp   (rgrp),
    .hit    (hit),
    .wr_en  (wr_en),
    .wr_dir (wr_dir),
    .wr_dat (wr_dat),
    .wr_inv (wr_inv),
    .wr_mode(wr_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= cfg_wdata[GROUPS-1:0];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    gpio_bank_group u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_dir  (wr_dir[g]),
      .wr_dat  (wr_dat[g]),
      .wr_inv  (wr_inv[g]),
      .wr_mode (wr_mode[g]),
      .wdata   (cfg_wdata),
      .grp_en  (en_q[g]),
      .smp     (pin_smp[g*GRP_W +: GRP_W]),
      .dir_o   (dir_a[g]),
      .lat_o   (lat_a[g]),
      .inv_o   (inv_a[g]),
      .mode_o  (mode_a[g]),
      .oe_o    (pin_oe[g*GRP_W +: GRP_W]),
      .val_o   (pin_out[g*GRP_W +: GRP_W]),
      .rd_val_o(rd_a[g])
    );
    assign dir_flat[g*GRP_W +: GRP_W]  = dir_a[g];
    assign lat_flat[g*GRP_W +: GRP_W]  = lat_a[g];
    assign inv_flat[g*GRP_W +: GRP_W]  = inv_a[g];
    assign mode_flat[g*GRP_W +: GRP_W] = mode_a[g];
  end

  always_comb begin
    cfg_rdata = '0;
    case (rsel)
      RSEL_EN:   cfg_rdata[GROUPS-1:0] = en_q;
      RSEL_DIR:  cfg_rdata = dir_a[rgrp];
      RSEL_DAT:  cfg_rdata = rd_a[rgrp];
      RSEL_INV:  cfg_rdata = inv_a[rgrp];
      RSEL_MODE: cfg_rdata = mode_a[rgrp];
      default:   cfg_rdata = '0;
    endcase
  end

  assert_no_value_without_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (~pin_oe & pin_out) == '0);

  assert_stray_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !hit) |=> $stable({en_q, dir_flat, lat_flat, inv_flat, mode_flat}));

  assert_stray_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (cfg_rdata == 8'h00));

endmodule

// File: tb/gpio_banked_ctrl_tb.sv
module gpio_banked_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_ldn = 8'h00;
  logic [7:0]  cfg_addr = 8'h00;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_oe;
  logic [15:0] pin_out;

  always #4 clk = ~clk;

  gpio_banked_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ldn(cfg_ldn), .cfg_addr(cfg_addr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  m_dir [2];
  logic [7:0]  m_dat [2];
  logic [7:0]  m_inv [2];
  logic [7:0]  m_mode[2];
  logic [1:0]  m_en;
  logic [15:0] pins_now;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int g = 0; g < 2; g++) begin
      m_dir[g] = 8'hFF; m_dat[g] = 8'h00; m_inv[g] = 8'h00; m_mode[g] = 8'h00;
    end
    m_en = 2'b00;
  endfunction

  function automatic void model_write(logic [7:0] ldn, logic [7:0] a, logic [7:0] d);
    if (ldn == 8'h07) begin
      case (a)
        8'h30: m_en = d[1:0];
        8'hE0: m_dir[0] = d;
        8'hE1: m_dat[0] = d;
        8'hE2: m_inv[0] = d;
        8'hE4: m_dir[1] = d;
        8'hE5: m_dat[1] = d;
        8'hE6: m_inv[1] = d;
        default: ;
      endcase
    end else if (ldn == 8'h0F) begin
      if (a == 8'hE0) m_mode[0] = d;
      if (a == 8'hE1) m_mode[1] = d;
    end
  endfunction

  function automatic logic [7:0] data_view(int g);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) begin
      logic lvl;
      lvl  = m_dir[g][b] ? pins_now[g*8+b] : m_dat[g][b];
      v[b] = m_en[g] ? (lvl ^ m_inv[g][b]) : 1'b0;
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] ldn, logic [7:0] a);
    if (ldn == 8'h07) begin
      case (a)
        8'h30: return {6'b0, m_en};
        8'hE0: return m_dir[0];
        8'hE1: return data_view(0);
        8'hE2: return m_inv[0];
        8'hE4: return m_dir[1];
        8'hE5: return data_view(1);
        8'hE6: return m_inv[1];
        default: return 8'h00;
      endcase
    end else if (ldn == 8'h0F) begin
      if (a == 8'hE0) return m_mode[0];
      if (a == 8'hE1) return m_mode[1];
    end
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_pads();
    logic [15:0] oe, o;
    for (int p = 0; p < 16; p++) begin
      int g, b;
      logic lvl;
      g = p / 8; b = p % 8;
      lvl = m_dat[g][b] ^ m_inv[g][b];
      oe[p] = 1'b0; o[p] = 1'b0;
      if (m_en[g] && !m_dir[g][b]) begin
        if (m_mode[g][b]) oe[p] = ~lvl;
        else begin oe[p] = 1'b1; o[p] = lvl; end
      end
    end
    return {oe, o};
  endfunction

  task automatic do_wr(logic [7:0] ldn, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_ldn = ldn; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(ldn, a, d);
  endtask

  task automatic rd_chk(string req, logic [7:0] ldn, logic [7:0] a);
    cfg_ldn = ldn; cfg_addr = a;
    #1;
    chk(req, {24'b0, cfg_rdata}, {24'b0, exp_read(ldn, a)},
        $sformatf("read ldn=%h addr=%h", ldn, a));
  endtask

  task automatic pads_chk(string req);
    #1;
    chk(req, {pin_oe, pin_out}, exp_pads(), "pin_oe/pin_out");
  endtask

  task automatic set_pins(logic [15:0] v);
    @(negedge clk);
    pin_in = v; pins_now = v;
    repeat (2) @(negedge clk);
  endtask

  function automatic void pick(int idx, output logic [7:0] l, output logic [7:0] a);
    case (idx)
      0: begin l = 8'h07; a = 8'h30; end
      1: begin l = 8'h07; a = 8'hE0; end
      2: begin l = 8'h07; a = 8'hE1; end
      3: begin l = 8'h07; a = 8'hE2; end
      4: begin l = 8'h07; a = 8'hE4; end
      5: begin l = 8'h07; a = 8'hE5; end
      6: begin l = 8'h07; a = 8'hE6; end
      7: begin l = 8'h0F; a = 8'hE0; end
      8: begin l = 8'h0F; a = 8'hE1; end
      default: begin l = 8'($urandom); a = 8'($urandom); end
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    pins_now = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    pads_chk("R1");
    for (int i = 0; i < 9; i++) begin
      logic [7:0] l, a;
      pick(i, l, a);
      rd_chk("R1", l, a);
    end

    // R2, R4: enable both groups, pins 4-7 outputs push-pull
    do_wr(8'h07, 8'h30, 8'hFF);
    rd_chk("R2", 8'h07, 8'h30);
    do_wr(8'h07, 8'hE0, 8'h0F);
    do_wr(8'h07, 8'hE1, 8'hA5);
    pads_chk("R4");
    do_wr(8'h07, 8'hE2, 8'hFF);
    pads_chk("R4");
    // R3: group 1 all inputs by reset, no drive
    chk("R3", {16'b0, pin_oe[15:8], 8'b0}, 32'h0, "group1 oe");
    // R5: open-drain on pins 4-7, both polarities
    do_wr(8'h0F, 8'hE0, 8'hF0);
    pads_chk("R5");
    do_wr(8'h07, 8'hE2, 8'h00);
    pads_chk("R5");
    rd_chk("R2", 8'h0F, 8'hE0);
    // R6: mixed data read with inputs
    set_pins(16'h5A0C);
    rd_chk("R6", 8'h07, 8'hE1);
    do_wr(8'h07, 8'hE2, 8'h3C);
    rd_chk("R6", 8'h07, 8'hE1);
    // R7: group 1 outputs then disabled
    do_wr(8'h07, 8'hE4, 8'h00);
    do_wr(8'h07, 8'hE5, 8'hFF);
    pads_chk("R7");
    do_wr(8'h07, 8'h30, 8'h01);
    pads_chk("R7");
    rd_chk("R7", 8'h07, 8'hE5);
    // R9: stray writes and reads
    do_wr(8'h07, 8'hE3, 8'h55);
    do_wr(8'h08, 8'hE0, 8'h55);
    do_wr(8'h0F, 8'hE2, 8'h55);
    do_wr(8'h07, 8'h31, 8'h00);
    pads_chk("R9");
    rd_chk("R9", 8'h07, 8'hE3);
    rd_chk("R9", 8'h08, 8'hE0);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] l, a;
      pick(i, l, a);
      rd_chk("R9", l, a);
    end

    // R8: synchronizer depth
    do_wr(8'h07, 8'h30, 8'h03);
    do_wr(8'h07, 8'hE0, 8'hFF);
    do_wr(8'h07, 8'hE2, 8'h00);
    set_pins(16'h0000);
    @(negedge clk);
    pin_in = 16'h00FF;
    @(negedge clk);
    cfg_ldn = 8'h07; cfg_addr = 8'hE1; #1;
    chk("R8", {24'b0, cfg_rdata}, 32'h00, "after one edge");
    @(negedge clk);
    cfg_ldn = 8'h07; cfg_addr = 8'hE1; #1;
    chk("R8", {24'b0, cfg_rdata}, 32'hFF, "after two edges");
    pins_now = 16'h00FF;

    // Random phase: R2 R4 R5 R6 R7 R9 mixed
    for (int it = 0; it < 400; it++) begin
      logic [7:0] l, a;
      pick(int'($urandom % 11), l, a);
      do_wr(l, a, 8'($urandom));
      if ((it % 4) == 0) set_pins(16'($urandom));
      pads_chk("RND_R4_R5");
      pick(int'($urandom % 10), l, a);
      rd_chk("RND_R6", l, a);
    end

    finish_run();
  end

endmodule